// File: doc/BRIEF.md
# Grouped Priority Preemption Arbiter

This block picks one interrupt request out of a set of request lines and decides whether it may interrupt the handler now running. Each line has an enable bit, a pending bit and a 4-bit priority. A 3-bit group code splits every priority into two parts. The upper part is the preemption value and the rest is the sub-priority.

Among enabled pending lines, the winner is the one with the numerically lowest priority. When two lines have equal priority, the line that has waited longer wins, and after that the lower line number. A winner is offered to the core only if no handler is running, or if its preemption value is strictly below the running level. The sub-priority therefore orders waiting requests but never interrupts a handler.

The core accepts an offer with `take_ack`, which pushes that line's preemption value onto a stack of nested levels. It signals the end of a handler with `handler_done`, which pops the stack and returns to the previous level. The core clears the taken line's pending bit itself.

Top module: `prio_preempt_arb`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `req_valid`, `active` and `run_level` are 0.
- R2: Group codes 7, 6, 5, 4 and 3 give 0, 1, 2, 3 and 4 preemption bits. These bits are the most significant bits of the 4-bit priority. `run_level` reports the preemption part in place, with the sub-priority bits forced to 0.
- R3: Group codes 0, 1 and 2 behave as code 7, which gives 0 preemption bits. With such a code, no request can preempt a running handler.
- R4: Among enabled pending lines, the offered line has the lowest 4-bit priority value. This compares the preemption part first and the sub-priority second.
- R5: For equal priority values, the line that has been enabled and pending for more cycles wins. Waiting is counted up to 15 cycles. For equal priority and equal waiting, the lower line number wins.
- R6: With a handler running, a line is offered only if its preemption part is strictly lower than `run_level`. When idle, any enabled pending line may be offered.
- R7: A line whose preemption part equals `run_level` is never offered, even if its sub-priority is better.
- R8: `take_ack` while `req_valid` is high pushes the offered preemption part. On the next cycle `active` is 1 and `run_level` equals that value.
- R9: `handler_done` pops one level, and `run_level` returns to the level beneath it, or to idle. `handler_done` while idle has no effect.
- R10: The outputs are registered and show the inputs one clock later. The offer is evaluated against the level after any push or pop in the same cycle, so a line just taken is not offered again.
- R11: A line whose enable bit is 0 is never offered, whatever its pending bit and priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_sel | input | 3 | Priority group code (held at bits 10:8 of the control word) |
| line_en | input | N_LINES | Per-line enable |
| line_pend | input | N_LINES | Per-line pending |
| line_prio | input | N_LINES*PRIO_W | Per-line priority; line i at bits [i*PRIO_W +: PRIO_W] |
| take_ack | input | 1 | Core accepts the current offer |
| handler_done | input | 1 | Running handler has completed |
| req_valid | output | 1 | An offer is present |
| req_line | output | $clog2(N_LINES) | Offered line number |
| req_prio | output | PRIO_W | Full priority of the offered line |
| active | output | 1 | At least one handler is running |
| run_level | output | PRIO_W | Preemption part of the running handler, sub bits 0 |

## Verification
The assertions check four things on every cycle: any offer made during a handler is strictly below the running level, a take sets the running level one cycle later, a completion while idle leaves the block idle, and an offered line was enabled and pending. What only the bench scenarios can show is the winner's identity under the group codes, tie-breaking by waiting time and by line number, and the worked three-line nesting case. They also show the rollback to the previous level after a completion, and invalid group codes behaving as the zero-bit code.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  // Group codes, named by the number of preemption bits they select
  typedef enum logic [2:0] {
    GRP_P0 = 3'd7,
    GRP_P1 = 3'd6,
    GRP_P2 = 3'd5,
    GRP_P3 = 3'd4,
    GRP_P4 = 3'd3
  } grp_code_e;
endpackage

// File: rtl/ppa_split.sv
// Turns the group code into a mask that keeps the preemption bits (MSBs)
module ppa_split #(
  parameter int PRIO_W = 4
) (
  input  logic [2:0]        grp_sel,
  output logic [PRIO_W-1:0] pre_mask
);
  import ppa_pkg::*;

  int pb;

  always_comb begin
    case (grp_sel)
      GRP_P1:  pb = 1;
      GRP_P2:  pb = 2;
      GRP_P3:  pb = 3;
      GRP_P4:  pb = 4;
      default: pb = 0;   // R3: codes outside 3..7 act as 0 preemption bits
    endcase
    if (pb > PRIO_W) pb = PRIO_W;
    for (int i = 0; i < PRIO_W; i++)
      pre_mask[i] = (i >= PRIO_W - pb);
  end
endmodule

// File: rtl/ppa_age.sv
// Per-line saturating wait counters for the arrival-order tie break
module ppa_age #(
  parameter int N_LINES = 82,
  parameter int AGE_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_LINES-1:0]       live,
  output logic [N_LINES*AGE_W-1:0] age
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  for (genvar i = 0; i < N_LINES; i++) begin : g_cnt
    logic [AGE_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst || !live[i]) cnt_q <= '0;
      else if (cnt_q != AGE_MAX) cnt_q <= cnt_q + 1'b1;
    end
    assign age[i*AGE_W +: AGE_W] = cnt_q;
  end
endmodule

// File: rtl/ppa_select.sv
// Picks the best eligible line: lowest priority, then oldest, then lowest index
module ppa_select #(
  parameter int N_LINES = 82,
  parameter int PRIO_W  = 4,
  parameter int AGE_W   = 4,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]        elig,
  input  logic [N_LINES*PRIO_W-1:0] prio,
  input  logic [N_LINES*AGE_W-1:0]  age,
  output logic                      found,
  output logic [IDX_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  logic [AGE_W-1:0] win_age;

  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    win_age  = '0;
    // scanning upward with strict compares leaves full ties to the lower index
    for (int i = 0; i < N_LINES; i++) begin
      if (elig[i]) begin
        if (!found ||
            prio[i*PRIO_W +: PRIO_W] < win_prio ||
            (prio[i*PRIO_W +: PRIO_W] == win_prio &&
             age[i*AGE_W +: AGE_W] > win_age)) begin
          found    = 1'b1;
          win_idx  = IDX_W'(i);
          win_prio = prio[i*PRIO_W +: PRIO_W];
          win_age  = age[i*AGE_W +: AGE_W];
        end
      end
    end
  end
endmodule

// File: rtl/ppa_stack.sv
// Stack of nested preemption levels; exposes its next state for lookahead
module ppa_stack #(
  parameter int DEPTH  = 16,
  parameter int PRIO_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_val,
  input  logic              pop,
  output logic [CNT_W-1:0]  nxt_cnt,
  output logic [PRIO_W-1:0] nxt_top,
  output logic              nxt_full
);
  logic [PRIO_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q, base;
  logic              do_pop, do_push;
  logic [AW-1:0]     wr_idx, rd_idx;

  always_comb begin
    do_pop   = pop && (cnt_q != '0);
    base     = cnt_q - CNT_W'(do_pop);
    do_push  = push && (base < CNT_W'(DEPTH));
    nxt_cnt  = base + CNT_W'(do_push);
    wr_idx   = AW'(base);
    rd_idx   = AW'(nxt_cnt - 1'b1);
    nxt_full = (nxt_cnt == CNT_W'(DEPTH));
    if (do_push)             nxt_top = push_val;
    else if (nxt_cnt == '0)  nxt_top = '0;
    else                     nxt_top = mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt_cnt;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_val;
  end
endmodule

// File: rtl/prio_preempt_arb.sv
module prio_preempt_arb #(
  parameter int N_LINES = 82,
  parameter int PRIO_W  = 4,
  parameter int AGE_W   = 4,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int DEPTH  = 1 << PRIO_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [2:0]                grp_sel,
  input  logic [N_LINES-1:0]        line_en,
  input  logic [N_LINES-1:0]        line_pend,
  input  logic [N_LINES*PRIO_W-1:0] line_prio,
  input  logic                      take_ack,
  input  logic                      handler_done,
  output logic                      req_valid,
  output logic [IDX_W-1:0]          req_line,
  output logic [PRIO_W-1:0]         req_prio,
  output logic                      active,
  output logic [PRIO_W-1:0]         run_level
);
  logic [PRIO_W-1:0]        pre_mask;
  logic [N_LINES-1:0]       live, elig;
  logic [N_LINES*AGE_W-1:0] age;
  logic [CNT_W-1:0]         nxt_cnt;
  logic [PRIO_W-1:0]        nxt_top;
  logic                     nxt_full;
  logic                     found;
  logic [IDX_W-1:0]         win_idx;
  logic [PRIO_W-1:0]        win_prio;
  logic [PRIO_W-1:0]        req_pre;

  assign live = line_en & line_pend;

  ppa_split #(.PRIO_W(PRIO_W)) u_split (
    .grp_sel (grp_sel),
    .pre_mask(pre_mask)
  );

  ppa_age #(.N_LINES(N_LINES), .AGE_W(AGE_W)) u_age (
    .clk (clk),
    .rst (rst),
    .live(live),
    .age (age)
  );

  ppa_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (take_ack && req_valid),
    .push_val(req_pre),
    .pop     (handler_done),
    .nxt_cnt (nxt_cnt),
    .nxt_top (nxt_top),
    .nxt_full(nxt_full)
  );

  // preemption test uses the level after this cycle's push/pop
  for (genvar i = 0; i < N_LINES; i++) begin : g_elig
    logic [PRIO_W-1:0] ap;
    assign ap      = line_prio[i*PRIO_W +: PRIO_W] & pre_mask;
    assign elig[i] = live[i] && !nxt_full && ((nxt_cnt == '0) || (ap < nxt_top));
  end

  ppa_select #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_sel (
    .elig    (elig),
    .prio    (line_prio),
    .age     (age),
    .found   (found),
    .win_idx (win_idx),
    .win_prio(win_prio)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_line  <= '0;
      req_prio  <= '0;
      req_pre   <= '0;
      active    <= 1'b0;
      run_level <= '0;
    end else begin
      req_valid <= found;
      req_line  <= win_idx;
      req_prio  <= win_prio;
      req_pre   <= win_prio & pre_mask;
      active    <= (nxt_cnt != '0);
      run_level <= (nxt_cnt != '0) ? nxt_top : '0;
    end
  end
endmodule

// File: rtl/ppa_checker.sv
module ppa_checker #(
  parameter int N_LINES = 82,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 7
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] line_en,
  input logic [N_LINES-1:0] line_pend,
  input logic               take_ack,
  input logic               handler_done,
  input logic               req_valid,
  input logic [IDX_W-1:0]   req_line,
  input logic [PRIO_W-1:0]  req_pre,
  input logic               active,
  input logic [PRIO_W-1:0]  run_level
);
  logic [N_LINES-1:0] live_d;
  always_ff @(posedge clk) live_d <= line_en & line_pend;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!req_valid && !active && run_level == '0));

  a_r6_strict_preempt: assert property (@(posedge clk) disable iff (rst)
    (req_valid && active) |-> (req_pre < run_level));

  a_r8_push_level: assert property (@(posedge clk) disable iff (rst)
    (take_ack && req_valid && !handler_done) |=> (active && run_level == $past(req_pre)));

  a_r9_idle_done: assert property (@(posedge clk) disable iff (rst)
    (handler_done && !active && !(take_ack && req_valid)) |=> !active);

  a_r11_offer_live: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> live_d[req_line]);
endmodule

bind prio_preempt_arb ppa_checker #(
  .N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .line_en     (line_en),
  .line_pend   (line_pend),
  .take_ack    (take_ack),
  .handler_done(handler_done),
  .req_valid   (req_valid),
  .req_line    (req_line),
  .req_pre     (req_pre),
  .active      (active),
  .run_level   (run_level)
);

// File: tb/prio_preempt_arb_bench.sv
module prio_preempt_arb_bench;
  localparam int N  = 82;
  localparam int PW = 4;
  localparam int IW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2:0]      grp_sel = 3'd7;
  logic [N-1:0]    line_en = '1;
  logic [N-1:0]    line_pend = '0;
  logic [N*PW-1:0] line_prio = '0;
  logic            take_ack = 1'b0;
  logic            handler_done = 1'b0;
  logic            req_valid;
  logic [IW-1:0]   req_line;
  logic [PW-1:0]   req_prio;
  logic            active;
  logic [PW-1:0]   run_level;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  prio_preempt_arb u_prio_preempt_arb (
    .clk(clk), .rst(rst), .grp_sel(grp_sel), .line_en(line_en),
    .line_pend(line_pend), .line_prio(line_prio), .take_ack(take_ack),
    .handler_done(handler_done), .req_valid(req_valid), .req_line(req_line),
    .req_prio(req_prio), .active(active), .run_level(run_level)
  );

  // fields: grp[31:29] lineA[28:22] prioA[21:18] lineB[17:11] prioB[10:7] winner[6:0]
  localparam logic [31:0] VEC [8] = '{
    {3'd7, 7'd5,  4'd3,  7'd9,  4'd2,  7'd9 },
    {3'd5, 7'd3,  4'd9,  7'd7,  4'd8,  7'd7 },
    {3'd5, 7'd6,  4'd12, 7'd3,  4'd9,  7'd3 },
    {3'd3, 7'd20, 4'd4,  7'd11, 4'd4,  7'd11},
    {3'd4, 7'd81, 4'd0,  7'd0,  4'd1,  7'd81},
    {3'd0, 7'd40, 4'd6,  7'd41, 4'd5,  7'd41},
    {3'd6, 7'd2,  4'd15, 7'd1,  4'd15, 7'd1 },
    {3'd3, 7'd64, 4'd7,  7'd63, 4'd3,  7'd63}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; line_pend = '0; line_en = '1; line_prio = '0;
    take_ack = 1'b0; handler_done = 1'b0; grp_sel = 3'd7;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic set_prio(input int ln, input logic [PW-1:0] p);
    line_prio[ln*PW +: PW] = p;
  endtask

  // core accepts the offer, then clears the taken line's pending bit
  task automatic take();
    int ln;
    ln = int'(req_line);
    take_ack = 1'b1;
    step();
    take_ack = 1'b0;
    line_pend[ln] = 1'b0;
  endtask

  task automatic finish_one();
    handler_done = 1'b1;
    step();
    handler_done = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 reset req_valid", int'(req_valid), 0);
    chk("R1 reset active", int'(active), 0);
    chk("R1 reset run_level", int'(run_level), 0);

    // R4/R5/R2/R3 ordering table, two lines arriving together while idle
    for (int v = 0; v < 8; v++) begin
      do_reset();
      grp_sel = VEC[v][31:29];
      set_prio(int'(VEC[v][28:22]), VEC[v][21:18]);
      set_prio(int'(VEC[v][17:11]), VEC[v][10:7]);
      line_pend[VEC[v][28:22]] = 1'b1;
      line_pend[VEC[v][17:11]] = 1'b1;
      step();
      chk($sformatf("R4 vec%0d valid", v), int'(req_valid), 1);
      chk($sformatf("R5 vec%0d winner", v), int'(req_line), int'(VEC[v][6:0]));
    end

    // nesting example with 2 preemption bits: 6=(3,0) 3=(2,1) 7=(2,0)
    do_reset();
    grp_sel = 3'd5;
    set_prio(6, 4'd12); set_prio(3, 4'd9); set_prio(7, 4'd8);
    line_pend[6] = 1'b1;
    step();
    chk("R6 idle offer line", int'(req_line), 6);
    take();
    chk("R8 active after take", int'(active), 1);
    chk("R8 run_level after take", int'(run_level), 12);
    chk("R10 no re-offer of taken line", int'(req_valid), 0);
    line_pend[3] = 1'b1;
    step();
    chk("R6 preempt valid", int'(req_valid), 1);
    chk("R6 preempt line", int'(req_line), 3);
    take();
    chk("R8 nested run_level", int'(run_level), 8);
    line_pend[7] = 1'b1;
    step();
    chk("R7 equal level not offered", int'(req_valid), 0);
    step();
    chk("R7 equal level still held", int'(req_valid), 0);
    finish_one();
    chk("R9 pop returns level", int'(run_level), 12);
    chk("R9 pending line now offered", int'(req_line), 7);
    chk("R9 pending line valid", int'(req_valid), 1);
    take();
    finish_one();
    finish_one();
    chk("R9 back to idle", int'(active), 0);
    chk("R9 idle run_level", int'(run_level), 0);
    finish_one();
    chk("R9 done while idle ignored", int'(active), 0);

    // arrival order among equal priorities
    do_reset();
    set_prio(30, 4'd5); set_prio(4, 4'd5);
    line_pend[30] = 1'b1;
    step(); step();
    line_pend[4] = 1'b1;
    step();
    chk("R5 older request wins", int'(req_line), 30);

    // invalid group code: zero preemption bits, nothing preempts
    do_reset();
    grp_sel = 3'd1;
    set_prio(1, 4'd3); set_prio(2, 4'd0);
    line_pend[1] = 1'b1;
    step();
    take();
    chk("R3 run_level with 0 bits", int'(run_level), 0);
    chk("R3 active", int'(active), 1);
    line_pend[2] = 1'b1;
    step();
    chk("R3 no preemption", int'(req_valid), 0);

    // 4 preemption bits: a lower full value preempts
    do_reset();
    grp_sel = 3'd3;
    set_prio(1, 4'd6); set_prio(2, 4'd5);
    line_pend[1] = 1'b1;
    step();
    take();
    chk("R2 run_level 4 bits", int'(run_level), 6);
    line_pend[2] = 1'b1;
    step();
    chk("R2 preempt by lower value", int'(req_line), 2);
    chk("R2 preempt valid", int'(req_valid), 1);

    // disabled line
    do_reset();
    line_en[50] = 1'b0;
    line_pend[50] = 1'b1;
    step(); step();
    chk("R11 disabled not offered", int'(req_valid), 0);
    line_en[50] = 1'b1;
    step();
    chk("R11 offered once enabled", int'(req_line), 50);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1..all act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule